// File: doc/BRIEF.md
# Transmit Port Half-Word Assembler

This block sits between a narrow transmit data port and an interpolation filter. Samples arrive one half-word per clock on a `HALF_W`-bit port. The block joins pairs of halves into full `2*HALF_W`-bit words and hands each finished word downstream on a valid/data stream. A sync input marks the first half of a word. A configuration input chooses whether the upper or the lower half comes first.

Two more modes change the data path. In bypass mode every incoming half is a complete word. It is placed in the upper half of the output with zeros below, and sync plays no part. When quiet gating is enabled and the active-low quiet input is pulled low, the block stops passing data. It first pushes `FLUSH_WORDS` zero words so the downstream filter is cleared, then holds its output idle and at zero. After any interruption of normal assembly (reset, bypass or quiet), the block waits for a fresh sync before it builds words again.

Top module: `tx_half_assembler`

## Requirements
- R1: After reset, `word_valid` is 0 and `word_data` is 0.
- R2: In normal mode with `lsb_first`=0, a half A sampled with `half_sync`=1 followed by a half B sampled with `half_sync`=0 produces `word_valid`=1 with `word_data`={A,B} (A in bits [2*HALF_W-1:HALF_W]) in the cycle after B is sampled. The cycle after A is sampled shows `word_valid`=0.
- R3: With `lsb_first`=1, the same pair produces `word_data`={B,A}: the first half goes to the low bits.
- R4: Once aligned by a sync, halves without sync keep alternating first/second, so a continuous stream yields one word every two cycles.
- R5: A sync on what would be a second half discards the partial word. That half becomes the new first half and no word is emitted for it.
- R6: Until a sync is seen after reset, after leaving bypass or after leaving quiet, no word is emitted in normal mode.
- R7: With `bypass_en`=1, every cycle's half H gives `word_valid`=1 and `word_data`={H, HALF_W zeros} one cycle later.
- R8: In bypass mode the value of `half_sync` has no effect on the output.
- R9: When `quiet_gate_en`=1 and `quiet_n` goes low, the block emits exactly `FLUSH_WORDS` words of value 0 with `word_valid`=1, one per cycle, starting the cycle after quiet is first sampled.
- R10: While quiet stays active after the flush, `word_valid` is 0 and `word_data` is 0.
- R11: With `quiet_gate_en`=0, `quiet_n` has no effect on assembly or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | Treat each half as a full word |
| lsb_first | input | 1 | 1: low half arrives first |
| quiet_gate_en | input | 1 | Enable the quiet input |
| quiet_n | input | 1 | Active-low quiet request |
| half_in | input | HALF_W | Incoming half-word |
| half_sync | input | 1 | Marks the first half of a word |
| word_valid | output | 1 | Word strobe toward the interpolator |
| word_data | output | 2*HALF_W | Assembled word |

## Verification
The hardest case is quiet entry while a word is half assembled and earlier words are still visible on the output. The flush must start with zeros at once, last exactly `FLUSH_WORDS` cycles, and leave the block unaligned afterwards. The bench gets there by aligning, emitting a word and then loading a lone first half just before pulling `quiet_n` low. It keeps toggling sync and data during quiet. After release it drives an unsynced half before resynchronising, to confirm nothing leaks through.

// File: rtl/tx_half_assembler.sv
module tx_half_assembler #(
  parameter int HALF_W      = 6,
  parameter int FLUSH_WORDS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bypass_en,
  input  logic                lsb_first,
  input  logic                quiet_gate_en,
  input  logic                quiet_n,
  input  logic [HALF_W-1:0]   half_in,
  input  logic                half_sync,
  output logic                word_valid,
  output logic [2*HALF_W-1:0] word_data
);
  localparam int CW = $clog2(FLUSH_WORDS + 1);

  logic              quiet_act, quiet_d;
  logic              aligned, second;
  logic [HALF_W-1:0] first_q;
  logic [CW-1:0]     flush_cnt;

  assign quiet_act = quiet_gate_en & ~quiet_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_d    <= 1'b0;
      aligned    <= 1'b0;
      second     <= 1'b0;
      first_q    <= '0;
      flush_cnt  <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      quiet_d <= quiet_act;
      if (quiet_act) begin
        aligned   <= 1'b0;
        second    <= 1'b0;
        word_data <= '0;
        if (!quiet_d) begin
          flush_cnt  <= CW'(FLUSH_WORDS - 1);
          word_valid <= 1'b1;
        end else if (flush_cnt != '0) begin
          flush_cnt  <= flush_cnt - 1'b1;
          word_valid <= 1'b1;
        end else begin
          word_valid <= 1'b0;
        end
      end else if (bypass_en) begin
        aligned    <= 1'b0;
        second     <= 1'b0;
        word_valid <= 1'b1;
        word_data  <= {half_in, {HALF_W{1'b0}}};
      end else if (half_sync || (aligned && !second)) begin
        aligned    <= 1'b1;
        second     <= 1'b1;
        first_q    <= half_in;
        word_valid <= 1'b0;
      end else if (aligned) begin
        second     <= 1'b0;
        word_valid <= 1'b1;
        word_data  <= lsb_first ? {half_in, first_q} : {first_q, half_in};
      end else begin
        word_valid <= 1'b0;
      end
    end
  end
endmodule

module tx_half_assembler_chk #(
  parameter int HALF_W      = 6,
  parameter int FLUSH_WORDS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bypass_en,
  input logic                quiet_gate_en,
  input logic                quiet_n,
  input logic [HALF_W-1:0]   half_in,
  input logic                half_sync,
  input logic                word_valid,
  input logic [2*HALF_W-1:0] word_data
);
  localparam int QW = $clog2(FLUSH_WORDS + 2);
  logic          q_on;
  logic [QW-1:0] q_run;

  assign q_on = quiet_gate_en && !quiet_n;

  always_ff @(posedge clk) begin
    if (!rst_n)                               q_run <= '0;
    else if (!q_on)                           q_run <= '0;
    else if (q_run < QW'(FLUSH_WORDS))        q_run <= q_run + 1'b1;
  end

  AST_BYPASS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en && !q_on) |=> (word_valid && word_data == {$past(half_in), {HALF_W{1'b0}}})); // R7
  AST_SYNC_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_en && !q_on && half_sync) |=> !word_valid); // R5
  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    q_on |=> word_data == '0); // R10
  AST_FLUSH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (q_on && q_run < QW'(FLUSH_WORDS)) |=> word_valid); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_on && q_run >= QW'(FLUSH_WORDS)) |=> !word_valid); // R10
endmodule

bind tx_half_assembler tx_half_assembler_chk #(.HALF_W(HALF_W), .FLUSH_WORDS(FLUSH_WORDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .quiet_gate_en(quiet_gate_en),
  .quiet_n(quiet_n), .half_in(half_in), .half_sync(half_sync),
  .word_valid(word_valid), .word_data(word_data));

// File: tb/tx_half_assembler_tb.sv
`timescale 1ns/1ps
module tx_half_assembler_tb_top;
  localparam int HW = 6;
  localparam int FL = 4;

  logic clk = 1'b0;
  logic rst_n, bypass_en, lsb_first, quiet_gate_en, quiet_n, half_sync;
  logic [HW-1:0]   half_in;
  logic            word_valid;
  logic [2*HW-1:0] word_data;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tx_half_assembler #(.HALF_W(HW), .FLUSH_WORDS(FL)) dut_i (
    .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .lsb_first(lsb_first),
    .quiet_gate_en(quiet_gate_en), .quiet_n(quiet_n), .half_in(half_in),
    .half_sync(half_sync), .word_valid(word_valid), .word_data(word_data));

  task automatic drive(input logic [HW-1:0] h, input logic s);
    half_in = h; half_sync = s;
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [2*HW:0] exp);
    checks++;
    if ({word_valid, word_data} !== exp) begin
      errors++;
      $display("FAIL %s actual valid=%0b data=%h expected valid=%0b data=%h",
               req, word_valid, word_data, exp[2*HW], exp[2*HW-1:0]);
    end
  endtask

  task automatic no_word(input string req);
    checks++;
    if (word_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s actual valid=%0b expected valid=0", req, word_valid);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; bypass_en = 0; lsb_first = 0; quiet_gate_en = 0; quiet_n = 1;
    half_in = '0; half_sync = 0;
    repeat (3) @(posedge clk); #1;
    check("R1", '0);
    rst_n = 1;
    // R6: unsynced halves after reset
    for (int i = 0; i < 5; i++) begin drive(HW'(i + 20), 0); no_word("R6"); end
    // R2: all pairs, high half first
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++) begin
        drive(HW'(a), 1); no_word("R2");
        drive(HW'(b), 0); check("R2", {1'b1, HW'(a), HW'(b)});
      end
    // R3: all pairs, low half first
    lsb_first = 1;
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++) begin
        drive(HW'(a), 1); no_word("R3");
        drive(HW'(b), 0); check("R3", {1'b1, HW'(b), HW'(a)});
      end
    lsb_first = 0;
    // R4: one sync, then a continuous stream
    for (int k = 0; k < 32; k++) begin
      drive(HW'(k), k == 0); no_word("R4");
      drive(HW'(63 - k), 0); check("R4", {1'b1, HW'(k), HW'(63 - k)});
    end
    // R5: resync mid-word
    drive(6'd5, 1); no_word("R5");
    drive(6'd9, 1); no_word("R5");
    drive(6'd12, 0); check("R5", {1'b1, 6'd9, 6'd12});
    // R7 R8: bypass with sync toggling
    bypass_en = 1;
    for (int v = 0; v < 64; v++) begin
      drive(HW'(v), v[0]); check("R7", {1'b1, HW'(v), 6'd0});
      drive(HW'(v), !v[0]); check("R8", {1'b1, HW'(v), 6'd0});
    end
    bypass_en = 0;
    drive(6'd3, 0); no_word("R6");
    drive(6'd3, 0); no_word("R6");
    // R9 R10: quiet with a partial word pending
    quiet_gate_en = 1;
    drive(6'd1, 1); drive(6'd2, 0); check("R2", {1'b1, 6'd1, 6'd2});
    drive(6'd4, 1); no_word("R5");
    quiet_n = 0;
    for (int j = 0; j < FL + 3; j++) begin
      drive(HW'(j + 40), j[0]);
      if (j < FL) check("R9", {1'b1, 12'd0});
      else        check("R10", '0);
    end
    quiet_n = 1;
    drive(6'd6, 0); no_word("R6");
    drive(6'd7, 0); no_word("R6");
    drive(6'd6, 1); drive(6'd8, 0); check("R9", {1'b1, 6'd6, 6'd8});
    // R11: quiet_n ignored when gating disabled
    quiet_gate_en = 0; quiet_n = 0;
    drive(6'd10, 1); no_word("R11");
    drive(6'd11, 0); check("R11", {1'b1, 6'd10, 6'd11});
    drive(6'd12, 0); no_word("R11");
    drive(6'd13, 0); check("R11", {1'b1, 6'd12, 6'd13});
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule